// File: doc/BRIEF.md
# Column Readout Sequencer

This block drains the hit records held by a set of row loggers into one output stream. Each row logger keeps a small queue of records, and each record holds a time code, a 6-bit hit pattern and a 3-bit group identifier. The sequencer sits in the single readout column shared by every row. It runs without pause at the readout clock, which is about 60 MHz, one ninth of the 150 ns sampling period.

Every cycle the sequencer looks for the first row holding data, starting from a rotating pointer. It pops one record from that row and registers it, together with the number of the row it came from, onto the output with a valid strobe. Rows with nothing stored are passed over in the same cycle, so they cost no output slots. The row tag lets the full hit pattern be rebuilt off-chip.

Top module: `col_readout_seq`

## Requirements
- R1: After synchronous active-low reset the output valid is low, no pop is issued, and the first search starts at row 0, so the lowest-numbered non-empty row is served first.
- R2: In any cycle at most one row receives a pop, and a row whose empty flag is high never receives one.
- R3: A row's pop is high in the cycle its head record is captured. out_valid is high in the next cycle, and only in cycles that follow a pop.
- R4: A record at a row input is packed as {time, pattern, id}, with id in the lowest 3 bits and the time code in the top TIME_W bits. The word on out_time, out_pattern and out_id equals the record that was popped.
- R5: out_row carries the index of the row whose record is on the output.
- R6: After row k is served, the next search starts at row k+1 and wraps from the last row to row 0.
- R7: Whenever at least one row is non-empty, a pop is issued in that same cycle, whatever number of empty rows lie between the pointer and it.
- R8: When every row is empty, no pop is issued, the next cycle's output is invalid, and the search pointer does not move.
- R9: A row gives one record per visit. Two rows with backlogs alternate instead of one row draining first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_empty | input | NUM_ROWS | Per-row flag: row holds no record |
| row_rec | input | NUM_ROWS*(TIME_W+9) | Head record of each row, row r at bits r*REC_W upward |
| row_pop | output | NUM_ROWS | Per-row pop request, combinational |
| out_valid | output | 1 | Output word is valid this cycle |
| out_time | output | TIME_W | Time code of the output record |
| out_pattern | output | 6 | Hit pattern of the output record |
| out_id | output | 3 | Group identifier of the output record |
| out_row | output | ROW_W | Source row of the output record |

## Verification
Two things can happen in the same cycle: the pointer wraps from the last row back to row 0, and empty rows are skipped on the way to the chosen row. The bench provokes this by keeping only row 0 and the highest row busy, so every grant either crosses the wrap point or jumps over six empty rows. A long stretch of sparse, irregular arrivals then mixes both effects with backlogs that build up and drain. A behavioural model keeps per-row queues and its own pointer. On every clock it judges the pop vector, and in the following cycle the output word and row tag.

// File: rtl/crs_pkg.sv
// Package crs_pkg: shared helpers for the column readout sequencer.
// Assumes row indices are small non-negative integers below the row count.
package crs_pkg;

    // Next row index in round-robin order, wrapping at n.
    function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/crs_rr_pick.sv
// Module crs_rr_pick: rotating-priority search over the row request flags.
// Starting at ptr, it finds the first requesting row in cyclic order and
// returns a one-hot grant plus its index. Purely combinational.
// Assumes ptr < NUM_ROWS.
module crs_rr_pick #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_W    = 3
) (
    input  logic [NUM_ROWS-1:0] req,
    input  logic [ROW_W-1:0]    ptr,
    output logic [NUM_ROWS-1:0] grant,
    output logic                found,
    output logic [ROW_W-1:0]    gidx
);

    // Walk the rows from ptr and take the first one that requests.
    always_comb begin
        grant = '0;
        found = 1'b0;
        gidx  = '0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            int unsigned idx;
            idx = int'(ptr) + i;
            if (idx >= NUM_ROWS) idx = idx - NUM_ROWS;
            if (!found && req[idx]) begin
                found     = 1'b1;
                gidx      = ROW_W'(idx);
                grant[idx] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/crs_rec_mux.sv
// Module crs_rec_mux: selects the head record of the granted row.
// AND-OR structure driven by a one-hot grant. Assumes grant is one-hot
// or zero; with zero grant the output is zero.
module crs_rec_mux #(
    parameter int NUM_ROWS = 8,
    parameter int REC_W    = 17
) (
    input  logic [NUM_ROWS*REC_W-1:0] rec_flat,
    input  logic [NUM_ROWS-1:0]       grant,
    output logic [REC_W-1:0]          sel_rec
);

    logic [REC_W-1:0] masked [NUM_ROWS];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_mask
        // Gate one row's record with its grant bit.
        assign masked[g] = grant[g] ? rec_flat[g*REC_W +: REC_W] : '0;
    end

    // OR the gated records together into the selected record.
    always_comb begin
        sel_rec = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            sel_rec = sel_rec | masked[r];
        end
    end

endmodule

// File: rtl/crs_out_stage.sv
// Module crs_out_stage: output register for the readout word.
// It captures the selected record and row index in the cycle a row is
// granted, and drops valid in cycles with no grant.
// Assumes synchronous active-low reset.
module crs_out_stage #(
    parameter int REC_W = 17,
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REC_W-1:0] sel_rec,
    input  logic [ROW_W-1:0] sel_row,
    output logic             q_valid,
    output logic [REC_W-1:0] q_rec,
    output logic [ROW_W-1:0] q_row
);

    // Register the word on a grant; valid tracks whether a grant happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_rec   <= '0;
            q_row   <= '0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_rec <= sel_rec;
                q_row <= sel_row;
            end
        end
    end

endmodule

// File: rtl/col_readout_seq.sv
// Module col_readout_seq: round-robin readout of many row loggers into one
// word stream tagged with the source row. Each cycle it pops at most one
// record, skipping empty rows in the same cycle.
// Assumes each row logger pops its head on the clock edge where its pop
// input is high, and shows its new head and empty flag after that edge.
module col_readout_seq #(
    parameter int  NUM_ROWS = 8,
    parameter int  TIME_W   = 8,
    parameter int  PAT_W    = 6,
    parameter int  ID_W     = 3,
    localparam int REC_W    = TIME_W + PAT_W + ID_W,
    localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ROWS-1:0]       row_empty,
    input  logic [NUM_ROWS*REC_W-1:0] row_rec,
    output logic [NUM_ROWS-1:0]       row_pop,
    output logic                      out_valid,
    output logic [TIME_W-1:0]         out_time,
    output logic [PAT_W-1:0]          out_pattern,
    output logic [ID_W-1:0]           out_id,
    output logic [ROW_W-1:0]          out_row
);
    import crs_pkg::*;

    logic [ROW_W-1:0]    ptr;
    logic [NUM_ROWS-1:0] grant;
    logic                found;
    logic [ROW_W-1:0]    gidx;
    logic [REC_W-1:0]    sel_rec;
    logic [REC_W-1:0]    q_rec;
    logic                load;

    crs_rr_pick #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_pick (
        .req   (~row_empty),
        .ptr   (ptr),
        .grant (grant),
        .found (found),
        .gidx  (gidx)
    );

    crs_rec_mux #(.NUM_ROWS(NUM_ROWS), .REC_W(REC_W)) u_mux (
        .rec_flat (row_rec),
        .grant    (grant),
        .sel_rec  (sel_rec)
    );

    // Grants count only out of reset.
    assign load    = found & rst_n;
    assign row_pop = rst_n ? grant : '0;

    // Move the search start one past the row just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= ROW_W'(rr_next(int'(gidx), NUM_ROWS));
        end
    end

    crs_out_stage #(.REC_W(REC_W), .ROW_W(ROW_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .sel_rec (sel_rec),
        .sel_row (gidx),
        .q_valid (out_valid),
        .q_rec   (q_rec),
        .q_row   (out_row)
    );

    // Split the registered record into its fields.
    assign out_time    = q_rec[REC_W-1 -: TIME_W];
    assign out_pattern = q_rec[ID_W +: PAT_W];
    assign out_id      = q_rec[ID_W-1:0];

endmodule

// File: rtl/crs_checker.sv
// Module crs_checker: temporal properties of the column readout sequencer,
// attached to every instance of the top module by the bind below.
module crs_checker #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_ROWS-1:0] row_empty,
    input logic [NUM_ROWS-1:0] row_pop,
    input logic                out_valid,
    input logic [ROW_W-1:0]    out_row
);

    logic [NUM_ROWS-1:0] pop_q;

    // Remember last cycle's pop vector to check the row tag against it.
    always_ff @(posedge clk) begin
        if (!rst_n) pop_q <= '0;
        else        pop_q <= row_pop;
    end

    assert_pop_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_pop));

    assert_pop_not_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_pop & row_empty) == '0);

    assert_valid_after_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_pop) |=> out_valid);

    assert_idle_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|row_pop) |=> !out_valid);

    assert_no_idle_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_empty != '1) |-> (|row_pop));

    assert_row_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pop_q[out_row]);

endmodule

bind col_readout_seq crs_checker #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_empty (row_empty),
    .row_pop   (row_pop),
    .out_valid (out_valid),
    .out_row   (out_row)
);

// File: tb/tb_col_readout_seq.sv
`timescale 1ns/1ps
module tb_col_readout_seq;
    localparam int NR   = 8;
    localparam int TW   = 8;
    localparam int PW   = 6;
    localparam int IW   = 3;
    localparam int RW   = TW + PW + IW;
    localparam int ROWW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    row_empty;
    logic [NR*RW-1:0] row_rec;
    logic [NR-1:0]    row_pop;
    logic             out_valid;
    logic [TW-1:0]    out_time;
    logic [PW-1:0]    out_pattern;
    logic [IW-1:0]    out_id;
    logic [ROWW-1:0]  out_row;

    col_readout_seq #(.NUM_ROWS(NR), .TIME_W(TW), .PAT_W(PW), .ID_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .row_empty(row_empty), .row_rec(row_rec),
        .row_pop(row_pop), .out_valid(out_valid), .out_time(out_time),
        .out_pattern(out_pattern), .out_id(out_id), .out_row(out_row)
    );

    always #2.5 clk = ~clk;

    // Behavioural model state.
    logic [RW-1:0] q [NR][$];
    int            mptr = 0;
    int            pend_k = -1;
    bit            exp_valid = 1'b0;
    logic [RW-1:0] exp_rec = '0;
    int            exp_row = 0;
    int            seq = 1;
    int            checks = 0;
    int            errors = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive();
        for (int r = 0; r < NR; r++) begin
            row_empty[r] = (q[r].size() == 0);
            row_rec[r*RW +: RW] = (q[r].size() != 0) ? q[r][0] : '0;
        end
    endtask

    // One readout cycle: apply last pop, add arrivals, then judge outputs and pop.
    task automatic step(input logic [NR-1:0] add);
        int k;
        logic [NR-1:0] exp_pop;
        @(posedge clk);
        #1;
        if (pend_k >= 0) begin
            void'(q[pend_k].pop_front());
            mptr = (pend_k + 1) % NR;
        end
        for (int r = 0; r < NR; r++) begin
            if (add[r]) begin
                q[r].push_back(RW'(seq * 131 + r * 7));
                seq++;
            end
        end
        drive();
        @(negedge clk);
        // R3 R4 R5: registered word follows the previous cycle's pop.
        check(out_valid == exp_valid &&
              (!exp_valid || ({out_time, out_pattern, out_id} == exp_rec &&
                              int'(out_row) == exp_row)),
              "R3 R4 R5 output word",
              {out_valid, 5'd0, out_row, 8'd0, out_time, out_pattern, out_id},
              {exp_valid, 5'd0, ROWW'(exp_row), 8'd0, exp_rec});
        k = -1;
        for (int i = 0; i < NR; i++) begin
            int idx;
            idx = (mptr + i) % NR;
            if (k < 0 && q[idx].size() > 0) k = idx;
        end
        exp_pop = (k >= 0) ? (NR'(1) << k) : '0;
        // R2 R6 R7 R8 R9: pop choice against the model's round-robin order.
        check(row_pop == exp_pop, "R2 R6 R7 R8 R9 pop vector", 64'(row_pop), 64'(exp_pop));
        exp_valid = (k >= 0);
        if (k >= 0) begin
            exp_rec = q[k][0];
            exp_row = k;
        end
        pend_k = k;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
        check(row_pop == '0, "R1 pop in reset", 64'(row_pop), 64'd0);
        rst_n = 1'b1;
        step('1);
        // R1: all rows loaded at once, row 0 must be served first.
        check(row_pop == NR'(1), "R1 first grant at row 0", 64'(row_pop), 64'd1);
        repeat (10) step('0);                     // drain then idle (R8)
        repeat (4) step(8'h08);                   // single busy row
        repeat (4) step(8'h28);                   // two backlogs alternate (R9)
        repeat (6) step('0);
        repeat (8) step(8'h81);                   // wrap plus skip (R6, R7)
        repeat (12) step('0);
        for (int c = 0; c < 400; c++) begin
            step(NR'($urandom & $urandom & $urandom));
        end
        repeat (30) step('0);
        finish_run();
    end

endmodule